// File: doc/BRIEF.md
# BERT Pattern Generator

This block produces a serial test sequence for bit error rate testing and merges it into an outgoing serial stream. Three pattern families are available. The first is a 15-stage pseudorandom sequence. The second is a fixed word of programmable length, sent over and over. The third is a 32-bit word that alternates with its complement after a programmable number of repeats. The stream moves one bit per cycle in which the serial clock enable is high. On each such cycle the registered output carries either the through data or a generated bit.

The pattern configuration is captured only on a low-to-high edge of a load strobe. Software can therefore rewrite the configuration fields freely, and they take effect at a chosen moment. On that same edge the generator restarts from the beginning of its sequence. The enable, inversion and replacement-scope controls act live. The scope control picks one of two behaviours: every bit is replaced, or only the bits flagged by a payload-slot qualifier are replaced. Framing, line coding and host bus decode sit outside this block.

Top module: `bert_patgen`

## Requirements
- R1: A rising edge of `cfg_load` (low in the previous cycle, high in the current one) captures `cfg_sel`, `cfg_len`, `cfg_word` and `cfg_count` and restarts the generator. Keeping `cfg_load` high afterwards neither reloads nor restarts anything. Fields changed while `cfg_load` stays high are ignored until the next rising edge.
- R2: The captured `cfg_sel` picks the family. 3'b001 selects repeating word and 3'b010 selects alternating word. 3'b000 and every other code select pseudorandom.
- R3: Pseudorandom: the state s[14:0] is seeded to all ones at load. The emitted bit is s[14]. Each advance sets s to {s[13:0], s[14]^s[13]}, which is the polynomial x^15+x^14+1.
- R4: Repeating word: a length code n gives L = n+17 bits. The bits cfg_word[L-1] down to cfg_word[0] are sent in that order, then the sequence wraps to cfg_word[L-1].
- R5: Alternating word: cfg_word[31] down to cfg_word[0] is sent (cfg_count+1) times. Its complement is then sent (cfg_count+1) times, and the cycle repeats.
- R6: When `cfg_inv` is 1, every generated bit is inverted on its way to `dout`. Through data is never inverted.
- R7: When `cfg_enable` is 0, each enabled cycle copies `din` to `dout`.
- R8: When `cfg_enable` is 1 and `cfg_whole` is 1, every enabled bit is replaced. When `cfg_whole` is 0, only bits with `slot_payload`=1 are replaced, and the other bits carry `din`.
- R9: The generator advances by one bit only in cycles where `bit_en` is 1 and the bit is replaced. Otherwise the sequence resumes where it stopped.
- R10: `dout` is a register updated only in cycles where `bit_en` is 1. The new value is visible after that clock edge, and `dout` holds in every other cycle.
- R11: Synchronous active-high reset clears `dout` to 0, selects pseudorandom and seeds the pseudorandom state to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Serial clock enable, one bit per cycle when high |
| slot_payload | input | 1 | Marks the current bit as a payload bit |
| din | input | 1 | Through serial data |
| cfg_load | input | 1 | Load strobe, acts on its rising edge |
| cfg_sel | input | 3 | Pattern family select |
| cfg_len | input | 4 | Repeating-word length code |
| cfg_word | input | 32 | Pattern word |
| cfg_count | input | 8 | Alternating-word repeat count |
| cfg_inv | input | 1 | Invert generated bits |
| cfg_enable | input | 1 | Enable pattern insertion |
| cfg_whole | input | 1 | 1: replace every bit, 0: payload bits only |
| dout | output | 1 | Registered output serial data |

## Verification
The bench holds the load strobe high while it changes the word. A design that acts on the level instead of the edge would restart the sequence or adopt the new word. The bench covers the shortest and the longest repeating length, where an off-by-one in the length offset shifts the wrap point. It also covers alternating counts of zero and two, where a wrong repeat compare swaps to the complement one word early or late. In other runs the enable is low, the bit is outside the payload, or the serial clock enable is low. After each such run the bench checks that the sequence resumes exactly where it stopped, so a generator that advances on non-replaced bits shows up as a shifted sequence.

// File: rtl/bert_pkg.sv
package bert_pkg;

  typedef enum logic [1:0] {
    FAM_PRBS   = 2'd0,
    FAM_REPEAT = 2'd1,
    FAM_ALT    = 2'd2
  } pat_fam_e;

  // R2: codes 1 and 2 pick the word families, all others pseudorandom
  function automatic pat_fam_e decode_sel(input logic [2:0] sel);
    case (sel)
      3'd1:    return FAM_REPEAT;
      3'd2:    return FAM_ALT;
      default: return FAM_PRBS;
    endcase
  endfunction

endpackage

// File: rtl/bert_edge.sv
module bert_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic pulse
);

  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign pulse = lvl & ~lvl_q;

  // R1: a held level yields a single pulse
  p_one_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

endmodule

// File: rtl/bert_lfsr.sv
module bert_lfsr #(
  parameter int LFSR_W = 15,
  parameter int TAP    = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic adv,
  output logic bit_o
);

  logic [LFSR_W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst || load) st <= '1;
    else if (adv)    st <= {st[LFSR_W-2:0], st[LFSR_W-1] ^ st[TAP-1]};
  end

  assign bit_o = st[LFSR_W-1];

  // R3: the state never locks up in all zeros
  p_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    st != '0);

  // R1: the state is seeded on a load
  p_seed_r1: assert property (@(posedge clk) disable iff (rst)
    load |=> st == '1);

  // R9: the state is frozen when it is not advanced
  p_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    (!adv && !load) |=> $stable(st));

endmodule

// File: rtl/bert_wordseq.sv
module bert_wordseq #(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  input  logic              alt_in,
  input  logic [LEN_W-1:0]  len_in,
  input  logic [WORD_W-1:0] word_in,
  input  logic [CNT_W-1:0]  count_in,
  output logic              bit_o
);

  localparam int PTR_W    = $clog2(WORD_W);
  localparam int LEN_BASE = WORD_W - (1 << LEN_W) + 1;

  function automatic logic [PTR_W-1:0] limit_of(input logic alt, input logic [LEN_W-1:0] len);
    if (alt) return PTR_W'(WORD_W - 1);
    return PTR_W'(LEN_BASE - 1) + PTR_W'(len);
  endfunction

  logic              alt_s;
  logic [LEN_W-1:0]  len_s;
  logic [WORD_W-1:0] word_s;
  logic [CNT_W-1:0]  count_s;
  logic [PTR_W-1:0]  ptr;
  logic [CNT_W-1:0]  rep;
  logic              phase;
  logic [PTR_W-1:0]  limit_s;

  assign limit_s = limit_of(alt_s, len_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      alt_s   <= 1'b0;
      len_s   <= '0;
      word_s  <= '0;
      count_s <= '0;
      ptr     <= PTR_W'(LEN_BASE - 1);
      rep     <= '0;
      phase   <= 1'b0;
    end else if (load) begin
      alt_s   <= alt_in;
      len_s   <= len_in;
      word_s  <= word_in;
      count_s <= count_in;
      ptr     <= limit_of(alt_in, len_in);
      rep     <= '0;
      phase   <= 1'b0;
    end else if (adv) begin
      if (ptr == '0) begin
        ptr <= limit_s;
        if (alt_s) begin
          if (rep == count_s) begin
            rep   <= '0;
            phase <= ~phase;
          end else begin
            rep <= rep + 1'b1;
          end
        end
      end else begin
        ptr <= ptr - 1'b1;
      end
    end
  end

  assign bit_o = word_s[ptr] ^ (alt_s & phase);

  // R4: the bit pointer stays within the programmed length
  p_ptr_range_r4: assert property (@(posedge clk) disable iff (rst)
    ptr <= limit_s);

  // R5: the repeat counter never passes the programmed count
  p_rep_range_r5: assert property (@(posedge clk) disable iff (rst)
    rep <= count_s);

  // R9: no movement without an advance
  p_hold_seq_r9: assert property (@(posedge clk) disable iff (rst)
    (!adv && !load) |=> ($stable(ptr) && $stable(phase) && $stable(rep)));

endmodule

// File: rtl/bert_patgen.sv
module bert_patgen #(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 4,
  parameter int CNT_W  = 8,
  parameter int SEL_W  = 3,
  parameter int LFSR_W = 15,
  parameter int TAP    = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              slot_payload,
  input  logic              din,
  input  logic              cfg_load,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [WORD_W-1:0] cfg_word,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              cfg_inv,
  input  logic              cfg_enable,
  input  logic              cfg_whole,
  output logic              dout
);
  import bert_pkg::*;

  logic     load_p;
  logic     repl;
  logic     adv;
  logic     prbs_bit;
  logic     word_bit;
  logic     gen_bit;
  pat_fam_e fam_s;
  pat_fam_e fam_in;

  assign fam_in = decode_sel(3'(cfg_sel));

  bert_edge u_edge (
    .clk   (clk),
    .rst   (rst),
    .lvl   (cfg_load),
    .pulse (load_p)
  );

  assign repl = cfg_enable & (cfg_whole | slot_payload);
  assign adv  = bit_en & repl & ~load_p;

  bert_lfsr #(.LFSR_W(LFSR_W), .TAP(TAP)) u_lfsr (
    .clk   (clk),
    .rst   (rst),
    .load  (load_p),
    .adv   (adv),
    .bit_o (prbs_bit)
  );

  bert_wordseq #(.WORD_W(WORD_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .load     (load_p),
    .adv      (adv),
    .alt_in   (fam_in == FAM_ALT),
    .len_in   (cfg_len),
    .word_in  (cfg_word),
    .count_in (cfg_count),
    .bit_o    (word_bit)
  );

  always_ff @(posedge clk) begin
    if (rst)         fam_s <= FAM_PRBS;
    else if (load_p) fam_s <= fam_in;
  end

  assign gen_bit = (fam_s == FAM_PRBS) ? prbs_bit : word_bit;

  always_ff @(posedge clk) begin
    if (rst)         dout <= 1'b0;
    else if (bit_en) dout <= repl ? (gen_bit ^ cfg_inv) : din;
  end

  // R7: with insertion disabled the through data is copied
  p_passthru_r7: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !cfg_enable) |=> dout == $past(din));

  // R8: non-payload bits pass through in payload-only mode
  p_payload_pass_r8: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !cfg_whole && !slot_payload) |=> dout == $past(din));

  // R10: output holds without a serial clock enable
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(dout));

endmodule

// File: tb/bert_patgen_tb.sv
module bert_patgen_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_en = 1'b0;
  logic        slot_payload = 1'b0;
  logic        din = 1'b0;
  logic        cfg_load = 1'b0;
  logic [2:0]  cfg_sel = 3'd0;
  logic [3:0]  cfg_len = 4'd0;
  logic [31:0] cfg_word = '0;
  logic [7:0]  cfg_count = '0;
  logic        cfg_inv = 1'b0;
  logic        cfg_enable = 1'b1;
  logic        cfg_whole = 1'b1;
  logic        dout;

  always #2 clk = ~clk;

  bert_patgen u_dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .slot_payload(slot_payload), .din(din),
    .cfg_load(cfg_load), .cfg_sel(cfg_sel), .cfg_len(cfg_len), .cfg_word(cfg_word),
    .cfg_count(cfg_count), .cfg_inv(cfg_inv), .cfg_enable(cfg_enable),
    .cfg_whole(cfg_whole), .dout(dout)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // bench model state
  int          m_fam = 0;   // 0 prbs, 1 repeat, 2 alternate
  int          m_k = 0;
  logic [14:0] m_lfsr = '1;
  int          m_len = 0;
  logic [31:0] m_word = '0;
  int          m_cnt = 0;
  logic        m_prev = 1'b0;

  typedef struct packed {
    logic [2:0]  sel;
    logic [3:0]  len;
    logic [31:0] word;
    logic [7:0]  cnt;
    logic        inv;
    logic        whole;
    logic [7:0]  nbits;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{3'd0, 4'd0,  32'h0000_0000, 8'd0, 1'b0, 1'b1, 8'd60},
    '{3'd1, 4'd0,  32'hA5C3_1F0E, 8'd0, 1'b0, 1'b1, 8'd40},
    '{3'd1, 4'd15, 32'h1234_5678, 8'd0, 1'b1, 1'b1, 8'd70},
    '{3'd2, 4'd0,  32'hF0F0_00FF, 8'd0, 1'b0, 1'b1, 8'd140},
    '{3'd2, 4'd0,  32'h0000_FFFF, 8'd2, 1'b0, 1'b1, 8'd200},
    '{3'd5, 4'd0,  32'h0000_0000, 8'd0, 1'b0, 1'b0, 8'd60},
    '{3'd1, 4'd7,  32'hC0FF_EE11, 8'd0, 1'b1, 1'b0, 8'd60}
  };

  function automatic int fam_of(input logic [2:0] s);
    if (s == 3'd1) return 1;
    if (s == 3'd2) return 2;
    return 0;
  endfunction

  function automatic string tag_of(input int f);
    if (f == 1) return "R4";
    if (f == 2) return "R5";
    return "R3";
  endfunction

  function automatic logic model_bit();
    int l, w, ph;
    case (m_fam)
      1: begin
        l = m_len + 17;
        return m_word[l - 1 - (m_k % l)];
      end
      2: begin
        w  = m_k / 32;
        ph = (w / (m_cnt + 1)) % 2;
        return m_word[31 - (m_k % 32)] ^ ph[0];
      end
      default: return m_lfsr[14];
    endcase
  endfunction

  task automatic model_load();
    m_fam  = fam_of(cfg_sel);
    m_len  = int'(cfg_len);
    m_word = cfg_word;
    m_cnt  = int'(cfg_count);
    m_k    = 0;
    m_lfsr = '1;
  endtask

  task automatic check(input bit ok, input string tag, input logic act, input logic exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: dout=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle, then compare dout after the edge
  task automatic step(input logic en, input logic slot, input logic d, input string tag);
    logic e;
    @(negedge clk);
    bit_en = en; slot_payload = slot; din = d;
    if (en) begin
      if (cfg_enable && (cfg_whole || slot)) begin
        e = model_bit() ^ cfg_inv;
        m_k++;
        m_lfsr = {m_lfsr[13:0], m_lfsr[14] ^ m_lfsr[13]};
      end else begin
        e = d;
      end
    end else begin
      e = m_prev;
    end
    m_prev = e;
    @(posedge clk); #1;
    check(dout === e, tag, dout, e);
  endtask

  task automatic pulse_load(input bit hold);
    @(negedge clk);
    bit_en = 1'b0; cfg_load = 1'b1;
    @(negedge clk);
    if (!hold) cfg_load = 1'b0;
    model_load();
  endtask

  initial begin
    #(150000 * 4);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    // R11: reset output state
    check(dout === 1'b0, "R11 reset dout", dout, 1'b0);
    m_prev = 1'b0;
    // R11: default pseudorandom, seeded to ones, without any load
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b0, "R11 default seq");

    // table of configurations
    for (int v = 0; v < 7; v++) begin
      cfg_sel = VECS[v].sel; cfg_len = VECS[v].len; cfg_word = VECS[v].word;
      cfg_count = VECS[v].cnt; cfg_inv = VECS[v].inv; cfg_whole = VECS[v].whole;
      cfg_enable = 1'b1;
      pulse_load(1'b0);
      for (int i = 0; i < int'(VECS[v].nbits); i++)
        step(1'b1, (i % 3) != 0, i[0] ^ i[2],
             $sformatf("%s/R2/R6/R8 vec%0d", tag_of(fam_of(VECS[v].sel)), v));
    end

    // R1: held-high load neither restarts nor adopts new fields
    cfg_sel = 3'd1; cfg_len = 4'd3; cfg_word = 32'h000A_BCDE;
    cfg_inv = 1'b0; cfg_whole = 1'b1;
    pulse_load(1'b1);
    for (int i = 0; i < 25; i++) step(1'b1, 1'b1, 1'b0, "R1 held load");
    cfg_word = 32'hFFF5_4321; cfg_sel = 3'd2;
    for (int i = 0; i < 25; i++) step(1'b1, 1'b1, 1'b0, "R1 held load new fields");
    @(negedge clk); cfg_load = 1'b0;
    pulse_load(1'b0);
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 1'b0, "R1 reload");

    // R10 and R9: no serial enable holds output and sequence
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, i[0], "R10 hold");
    for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b0, "R9 resume after hold");

    // R7 and R9: insertion disabled passes data and freezes sequence
    cfg_enable = 1'b0;
    for (int i = 0; i < 12; i++) step(1'b1, 1'b1, i[1] ^ i[0], "R7 passthrough");
    cfg_enable = 1'b1;
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b1, "R9 resume after disable");

    // R8: payload-only with long non-payload gaps
    cfg_whole = 1'b0;
    for (int i = 0; i < 30; i++) step(1'b1, (i % 5) == 4, ~i[0], "R8 sparse payload");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule